// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Encoder

This block gathers external interrupt lines arranged in groups of sixteen. Each line passes through a two-flop synchronizer and then through a trigger detector. The detector's mode comes from a 4-bit field, and four neighbouring lines share one field. A detected event sets a sticky pending bit. Per-line mask bits decide whether a pending bit may reach the single combined interrupt output.

Software finds what to service next by reading one service byte. The upper nibble names the group, counted from 1, so that 0 can mean "nothing to do". The lower nibble names the line inside that group. The first group is split between two banks of eight pins: its lines 8 to 15 belong to the second bank.

Two groups share each 32-bit trigger, mask and pending word. Pending bits are cleared by writing ones to them.

Top module: `gpio_grp_irq`

## Requirements
- R1: While reset is asserted and right after it, every mask bit reads 1, every pending bit reads 0 and every trigger field reads 0. With all lines masked, irq_o is 0 and the service byte is 0x00.
- R2: Byte addresses are laid out as follows: trigger word w at 0x00+4w, mask word w at 0x20+4w, pending word w at 0x40+4w and the service byte at 0x60. Group g sits in word g/2, at bit offset 16*(g mod 2). Word bits that have no line behind them read 0.
- R3: Trigger field k of word w occupies bits [4k+3:4k]. It governs the interrupt bits 4k to 4k+3 of that same word.
- R4: The trigger codes are 0 for a low level, 1 for a high level, 2 for a falling edge, 4 for a rising edge and 6 for either edge. Any other code never sets a pending bit.
- R5: A line change applied between clock edges first shows as a pending bit after the third following rising clock edge. It is not visible after the second.
- R6: Pending bits are recorded whether or not the line is masked. A mask bit of 1 hides its pending bit from irq_o and from the service byte.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an event is detected in the same cycle as the clear, the pending bit stays set.
- R8: irq_o is 1 exactly when at least one pending bit is unmasked.
- R9: The service byte reports the lowest-numbered group that holds an unmasked pending bit, plus 1, in bits [7:4]. Bits [3:0] give the lowest such line within that group. The byte is 0x00 when no unmasked pending bit exists.
- R10: The first group serves two banks. Its lines 0 to 7 report pins 0 to 7. Second-bank pin p is line 8+p and reports pin 8+p under group value 1.
- R11: The service byte is read-only. Writes to 0x60 change no register, and a read of 0x60 returns the service byte zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lines_i | input | NG*16 | Asynchronous external interrupt lines, group-major |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Combined interrupt output |
| svc_o | output | 8 | Service byte: group+1 in [7:4], line in [3:0] |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a fresh detection. The stimulus holds a line at its active level under a level trigger and issues the clear while the detector still fires on every cycle. Service ordering is driven by several masked lines in different groups and banks that are pending together. The lines are then unmasked and cleared one at a time, so each step exposes the next priority winner. That sequence includes the second-bank pins of the shared group.

// File: rtl/gpio_grp_irq_pkg.sv
package gpio_grp_irq_pkg;
  localparam int LINES_PER_GRP = 16;
  localparam int WORD_W        = 32;
  localparam int FIELD_W       = 4;
  localparam int ADDR_W        = 8;

  typedef enum logic [3:0] {
    TRG_LOW  = 4'd0,
    TRG_HIGH = 4'd1,
    TRG_FALL = 4'd2,
    TRG_RISE = 4'd4,
    TRG_BOTH = 4'd6
  } trig_e;

  typedef enum logic [1:0] {
    RK_TRIG = 2'd0,
    RK_MASK = 2'd1,
    RK_PEND = 2'd2,
    RK_SVC  = 2'd3
  } reg_kind_e;

  // Event decision for one line from its current and previous synchronized sample.
  function automatic logic trig_hit(input logic [3:0] code, input logic cur, input logic prv);
    case (code)
      TRG_LOW:  return !cur;
      TRG_HIGH: return cur;
      TRG_FALL: return !cur && prv;
      TRG_RISE: return cur && !prv;
      TRG_BOTH: return cur != prv;
      default:  return 1'b0;
    endcase
  endfunction

  // Address is valid when bit 7 and the byte lane bits are zero.
  function automatic logic addr_ok(input logic [ADDR_W-1:0] a, input int nwords);
    return !a[7] && (a[1:0] == 2'b00) &&
           ((a[6:5] == RK_SVC) ? (a[4:2] == 3'd0) : (int'(a[4:2]) < nwords));
  endfunction
endpackage

// File: rtl/gint_sync.sv
module gint_sync #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prv_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] cur_q;
  logic [N-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur_o = cur_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/gint_event.sv
module gint_event import gpio_grp_irq_pkg::*; #(
  parameter int NL = 16
) (
  input  logic [NL-1:0] trig_i,
  input  logic [NL-1:0] cur_i,
  input  logic [NL-1:0] prv_i,
  output logic [NL-1:0] set_o
);
  // One 4-bit field per four consecutive lines: line i uses field at bit 4*(i/4).
  for (genvar i = 0; i < NL; i++) begin : g_line
    localparam int FB = (i / FIELD_W) * FIELD_W;
    assign set_o[i] = trig_hit(trig_i[FB +: FIELD_W], cur_i[i], prv_i[i]);
  end
endmodule

// File: rtl/gint_svc_enc.sv
module gint_svc_enc import gpio_grp_irq_pkg::*; #(
  parameter int NG = 9
) (
  input  logic [NG*LINES_PER_GRP-1:0] act_i,
  output logic [7:0]                  svc_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    svc_o = 8'h00;
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < LINES_PER_GRP; p++) begin
        if (!found && act_i[g*LINES_PER_GRP + p]) begin
          found = 1'b1;
          svc_o = {4'(g + 1), 4'(p)};
        end
      end
    end
  end
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq import gpio_grp_irq_pkg::*; #(
  parameter int NG = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NG*LINES_PER_GRP-1:0] lines_i,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        irq_o,
  output logic [7:0]                  svc_o
);
  localparam int NL = NG * LINES_PER_GRP;
  localparam int NW = (NG + 1) / 2;
  localparam int NP = NW * WORD_W;

  logic [NL-1:0] cur, prv;
  logic [NL-1:0] set_vec, clr_vec;
  logic [NL-1:0] trig_q, mask_q, pend_q;
  logic [NL-1:0] act;
  logic [NP-1:0] trig_pad, mask_pad, pend_pad;

  logic      wr_ok;
  reg_kind_e wr_kind, rd_kind;

  gint_sync #(.N(NL)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(lines_i),
    .cur_o  (cur),
    .prv_o  (prv)
  );

  gint_event #(.NL(NL)) u_event (
    .trig_i(trig_q),
    .cur_i (cur),
    .prv_i (prv),
    .set_o (set_vec)
  );

  assign wr_kind = reg_kind_e'(wr_addr[6:5]);
  assign rd_kind = reg_kind_e'(rd_addr[6:5]);
  assign wr_ok   = wr_en && addr_ok(wr_addr, NW);

  // Per-bit clear request from a pending-word write.
  always_comb begin
    for (int b = 0; b < NL; b++) begin
      clr_vec[b] = wr_ok && (wr_kind == RK_PEND) &&
                   (b / WORD_W == int'(wr_addr[4:2])) && wr_data[b % WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      for (int b = 0; b < NL; b++) begin
        if (wr_ok && (b / WORD_W == int'(wr_addr[4:2]))) begin
          if (wr_kind == RK_TRIG) trig_q[b] <= wr_data[b % WORD_W];
          if (wr_kind == RK_MASK) mask_q[b] <= wr_data[b % WORD_W];
        end
        pend_q[b] <= set_vec[b] | (pend_q[b] & ~clr_vec[b]);
      end
    end
  end

  assign act   = pend_q & ~mask_q;
  assign irq_o = |act;

  gint_svc_enc #(.NG(NG)) u_enc (
    .act_i(act),
    .svc_o(svc_o)
  );

  assign trig_pad = NP'(trig_q);
  assign mask_pad = NP'(mask_q);
  assign pend_pad = NP'(pend_q);

  always_comb begin
    rd_data = '0;
    if (addr_ok(rd_addr, NW)) begin
      if (rd_kind == RK_SVC) begin
        rd_data = {24'h0, svc_o};
      end else begin
        for (int w = 0; w < NW; w++) begin
          if (w == int'(rd_addr[4:2])) begin
            case (rd_kind)
              RK_TRIG: rd_data = trig_pad[w*WORD_W +: WORD_W];
              RK_MASK: rd_data = mask_pad[w*WORD_W +: WORD_W];
              default: rd_data = pend_pad[w*WORD_W +: WORD_W];
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpio_grp_irq_chk.sv
module gpio_grp_irq_chk import gpio_grp_irq_pkg::*; #(
  parameter int NG = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        irq_o,
  input logic [7:0]                  svc_o,
  input logic [NG*LINES_PER_GRP-1:0] mask_q,
  input logic [NG*LINES_PER_GRP-1:0] pend_q,
  input logic [NG*LINES_PER_GRP-1:0] set_vec,
  input logic [NG*LINES_PER_GRP-1:0] clr_vec
);
  localparam int NL = NG * LINES_PER_GRP;

  logic          live_q;
  int            sel_idx;
  logic [NL-1:0] act_chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign act_chk = pend_q & ~mask_q;
  assign sel_idx = (int'(svc_o[7:4]) - 1) * LINES_PER_GRP + int'(svc_o[3:0]);

  // R1: reset leaves every line masked
  p_reset_masked_r1: assert property (@(posedge clk) !rst_n |=> (mask_q == '1));

  // R8: combined output agrees with the encoder's idle indication
  p_irq_vs_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (svc_o != 8'h00));

  // R9: a non-idle service byte names an unmasked pending line
  p_svc_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o != 8'h00) |-> ((svc_o[7:4] != 4'd0) && (int'(svc_o[7:4]) <= NG) &&
                          (sel_idx < NL) && act_chk[sel_idx]));

  // R6: a detected event always lands in the pending bit
  p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(set_vec) & ~pend_q) == '0));

  // R4: pending bits only rise from a detected event
  p_no_spont_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

  // R7: a clear without a competing event empties the bit
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (($past(clr_vec & ~set_vec) & pend_q) == '0));
endmodule

bind gpio_grp_irq gpio_grp_irq_chk #(.NG(NG)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .irq_o  (irq_o),
  .svc_o  (svc_o),
  .mask_q (mask_q),
  .pend_q (pend_q),
  .set_vec(set_vec),
  .clr_vec(clr_vec)
);

// File: tb/gpio_grp_irq_test.sv
module gpio_grp_irq_test;
  localparam int NG = 9;
  localparam int NL = NG * 16;
  localparam int NW = (NG + 1) / 2;
  localparam int NV = 12;

  // {line[7:0], code[3:0], start, end, expected pending}
  localparam logic [14:0] VEC [NV] = '{
    {8'd0,   4'd4, 1'b0, 1'b1, 1'b1},
    {8'd5,   4'd4, 1'b1, 1'b0, 1'b0},
    {8'd17,  4'd2, 1'b1, 1'b0, 1'b1},
    {8'd18,  4'd2, 1'b0, 1'b1, 1'b0},
    {8'd40,  4'd6, 1'b0, 1'b1, 1'b1},
    {8'd41,  4'd6, 1'b1, 1'b0, 1'b1},
    {8'd63,  4'd1, 1'b0, 1'b1, 1'b1},
    {8'd70,  4'd1, 1'b0, 1'b0, 1'b0},
    {8'd100, 4'd0, 1'b1, 1'b0, 1'b1},
    {8'd101, 4'd0, 1'b1, 1'b1, 1'b0},
    {8'd143, 4'd3, 1'b0, 1'b1, 1'b0},
    {8'd130, 4'd5, 1'b1, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          irq_o;
  logic [7:0]    svc_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_grp_irq #(.NG(NG)) uut (
    .clk(clk), .rst_n(rst_n), .lines_i(lines),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .svc_o(svc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    // R1 / R2: reset contents, partial last word
    for (int w = 0; w < NW; w++) begin
      rd(8'h20 + 8'(4*w), d);
      chk("R1 mask reset", d, (w == NW-1) ? 32'h0000FFFF : 32'hFFFFFFFF);
    end
    rd(8'h40, d); chk("R1 pend reset", d, 32'h0);
    rd(8'h00, d); chk("R1 trig reset", d, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    chk("R1 svc after reset", {24'h0, svc_o}, 32'h0);

    // Quiet all detectors with an unused code, then clear
    for (int w = 0; w < NW; w++) wr(8'h00 + 8'(4*w), 32'hFFFFFFFF);
    idle(2);
    for (int w = 0; w < NW; w++) wr(8'h40 + 8'(4*w), 32'hFFFFFFFF);
    idle(1);
    rd(8'h40, d); chk("R4 unused code no set", d, 32'h0);

    // Table walk: R3/R4 trigger codes and field sharing
    for (int v = 0; v < NV; v++) begin
      int ln, w, f;
      logic [3:0] code;
      ln = int'(VEC[v][14:7]); code = VEC[v][6:3];
      w = ln / 32; f = (ln % 32) / 4;
      lines[ln] = VEC[v][2];
      wr(8'(4*w), (32'hFFFFFFFF & ~(32'hF << (4*f))) | (32'(code) << (4*f)));
      idle(5);
      wr(8'h40 + 8'(4*w), 32'hFFFFFFFF);
      idle(1);
      lines[ln] = VEC[v][1];
      idle(5);
      rd(8'h40 + 8'(4*w), d);
      chk($sformatf("R4 R3 vector %0d line %0d code %0d", v, ln, code),
          {31'h0, d[ln % 32]}, {31'h0, VEC[v][0]});
    end
    chk("R6 masked table irq", {31'h0, irq_o}, 32'h0);

    // Clean slate
    lines = '0;
    for (int w = 0; w < NW; w++) wr(8'h00 + 8'(4*w), 32'hFFFFFFFF);
    idle(6);
    for (int w = 0; w < NW; w++) wr(8'h40 + 8'(4*w), 32'hFFFFFFFF);
    wr(8'h00, 32'h44444444);
    wr(8'h04, 32'h44444444);
    wr(8'h10, 32'h44444444);
    idle(2);

    // R5: three-edge latency
    @(negedge clk); lines[1] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(8'h40, d); chk("R5 not after two edges", {31'h0, d[1]}, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(8'h40, d); chk("R5 visible after third edge", {31'h0, d[1]}, 32'h1);
    wr(8'h40, 32'h00000002);

    // R6: masked pending is recorded but hidden
    lines[3] = 1'b1; lines[12] = 1'b1; lines[20] = 1'b1;
    idle(5);
    rd(8'h40, d); chk("R6 recorded while masked", d, 32'h00101008);
    chk("R6 masked svc", {24'h0, svc_o}, 32'h0);
    chk("R6 masked irq", {31'h0, irq_o}, 32'h0);

    // R9 / R10 / R8: ordering after unmask
    wr(8'h20, 32'h00000000);
    chk("R9 lowest pin", {24'h0, svc_o}, 32'h13);
    chk("R8 irq on unmask", {31'h0, irq_o}, 32'h1);
    wr(8'h40, 32'h00000008);
    chk("R10 second bank pin 4", {24'h0, svc_o}, 32'h1C);
    wr(8'h40, 32'h00001000);
    chk("R9 next group", {24'h0, svc_o}, 32'h24);
    wr(8'h40, 32'h00100000);
    chk("R9 idle", {24'h0, svc_o}, 32'h0);
    chk("R8 irq idle", {31'h0, irq_o}, 32'h0);

    // R9: lower group wins over higher one
    wr(8'h30, 32'h00000000);
    lines[143] = 1'b1;
    idle(5);
    chk("R9 group 9 pin 15", {24'h0, svc_o}, 32'h9F);
    wr(8'h24, 32'h00000000);
    lines[40] = 1'b1;
    idle(5);
    chk("R9 lower group first", {24'h0, svc_o}, 32'h38);

    // R7: writing zero has no effect
    wr(8'h44, 32'h00000000);
    chk("R7 zero write keeps", {24'h0, svc_o}, 32'h38);

    // R11: service write ignored
    wr(8'h60, 32'hFFFFFFFF);
    rd(8'h60, d); chk("R11 read svc", d, 32'h38);
    rd(8'h20, d); chk("R11 mask untouched", d, 32'h0);
    rd(8'h00, d); chk("R11 trig untouched", d, 32'h44444444);

    // R7: event in the same cycle as clear keeps the bit
    wr(8'h10, 32'hFFFF1FFF);
    lines[140] = 1'b1;
    idle(5);
    wr(8'h50, 32'h00001000);
    rd(8'h50, d); chk("R7 set wins over clear", {31'h0, d[12]}, 32'h1);

    // R2: bits without a line read zero
    rd(8'h30, d); chk("R2 unused bits", d & 32'hFFFF0000, 32'h0);

    // R8: masking everything drops irq
    for (int w = 0; w < NW; w++) wr(8'h20 + 8'(4*w), 32'hFFFFFFFF);
    chk("R8 irq masked", {31'h0, irq_o}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule